// File: doc/BRIEF.md
# Dual-Channel Serial Converter Register Controller

This block is the digital front end of a two-channel 12-bit digital-to-analog converter. A host writes 16-bit command words over a three-wire serial port made of an active-low select, a serial clock and a data line. The same shift register that captures each word also drives a serial data output, so the previous word leaves the block bit by bit while the next one comes in. The serial pins are sampled by the block's system clock, which must run at least four times faster than the serial clock.

Each channel holds its value in two stages. An input register is written first. A converter register then drives that channel's output code. The top four bits of a word select a command, and the low twelve bits carry data. Commands can load either input register, copy both input registers to their converter registers, shut down either channel or both, and drive a general-purpose output pin.

An asynchronous active-low clear zeroes every register. A lockout input, while low, stops any channel from entering shutdown.

Top module: `dual_dac_ctrl`

## Requirements
- R1: A frame begins when `cs_n` falls. While `cs_n` is low, one bit of `din` is captured on each rising `sclk`, most significant bit first. The word is executed when `cs_n` rises. Bits [15:12] form the command and bits [11:0] form the data.
- R2: A frame that did not receive exactly 16 rising `sclk` edges is discarded when `cs_n` rises, and none of the outputs change.
- R3: `dout` always shows bit 15 of the shift register. Before the first rising edge of a frame it shows bit 15 of the previous frame, and after n rising edges it shows bit 15-n of that frame. `dout` does not change while `cs_n` stays high.
- R4: Command 0x1 writes the data to input register A, and command 0x2 writes it to input register B. Neither command changes `code_a` or `code_b`.
- R5: Command 0x5 copies both input registers to the converter registers. Command 0x3 loads input register A and then copies both, and command 0x4 does the same after loading input register B. In both cases the converter register takes the newly loaded value. `code_a` and `code_b` show the converter registers.
- R6: Command 0x6 sets `sd_a`, command 0x7 sets `sd_b`, and command 0x8 sets both. Shutdown keeps the contents of the input and converter registers, and the serial port keeps accepting frames.
- R7: A shutdown command executed while `pdl_n` is low has no effect. `pdl_n` is sampled at execution.
- R8: A load or update command clears the shutdown flag of each channel it writes. Command 0x1 clears `sd_a`, command 0x2 clears `sd_b`, and commands 0x3, 0x4 and 0x5 clear both.
- R9: Command 0xA sets `upo` and command 0x9 clears it. Command 0x0 and commands 0xB to 0xF change nothing.
- R10: While `clr_n` is low, the shift register, all four data registers, both shutdown flags and `upo` are zero, with no clock needed. This forces `code_a`, `code_b` and `dout` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| clr_n | input | 1 | Asynchronous active-low clear of all registers |
| pdl_n | input | 1 | Active-low lockout that blocks shutdown commands |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock; data is captured on its rising edge |
| din | input | 1 | Serial data in, most significant bit first |
| dout | output | 1 | Serial data out (shift register bit 15) |
| code_a | output | 12 | Converter register of channel A |
| code_b | output | 12 | Converter register of channel B |
| sd_a | output | 1 | Channel A shutdown flag |
| sd_b | output | 1 | Channel B shutdown flag |
| upo | output | 1 | General-purpose output bit |

## Verification
A rising `sclk` or `cs_n` takes effect at the first `clk` edge after it is seen, because one register stage detects the edge. A command's results therefore appear on `code_a`, `code_b`, `sd_a`, `sd_b` and `upo` after the first rising `clk` edge that follows `cs_n` going high. The bench changes the serial pins on falling `clk` edges and waits two falling edges before it samples any output. It checks `dout` just before each rising `sclk`, when the shift register has absorbed every earlier bit. The clear is checked a fraction of a cycle after `clr_n` falls, with no clock edge in between.

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl #(
  parameter int DW = 12,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          clr_n,
  input  logic          pdl_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          din,
  output logic          dout,
  output logic [DW-1:0] code_a,
  output logic [DW-1:0] code_b,
  output logic          sd_a,
  output logic          sd_b,
  output logic          upo
);

  localparam int FW = DW + CW;
  localparam int NW = $clog2(FW + 2);
  localparam logic [NW-1:0] NMAX = '1;
  localparam logic [NW-1:0] NFULL = NW'(FW);

  localparam logic [CW-1:0] C_LDA   = CW'(1);
  localparam logic [CW-1:0] C_LDB   = CW'(2);
  localparam logic [CW-1:0] C_LDAU  = CW'(3);
  localparam logic [CW-1:0] C_LDBU  = CW'(4);
  localparam logic [CW-1:0] C_UPD   = CW'(5);
  localparam logic [CW-1:0] C_OFFA  = CW'(6);
  localparam logic [CW-1:0] C_OFFB  = CW'(7);
  localparam logic [CW-1:0] C_OFFAB = CW'(8);
  localparam logic [CW-1:0] C_UPO0  = CW'(9);
  localparam logic [CW-1:0] C_UPO1  = CW'(10);

  logic          sclk_q, cs_q;
  logic [FW-1:0] sr;
  logic [NW-1:0] nbit;
  logic [DW-1:0] in_a, in_b;

  wire sclk_rise = sclk & ~sclk_q & ~cs_n;
  wire cs_rise   = cs_n & ~cs_q;
  wire cs_fall   = ~cs_n & cs_q;
  wire go        = cs_rise && (nbit == NFULL);

  wire [CW-1:0] cmd = sr[FW-1 -: CW];
  wire [DW-1:0] dat = sr[DW-1:0];

  wire ld_a   = go && (cmd == C_LDA || cmd == C_LDAU);
  wire ld_b   = go && (cmd == C_LDB || cmd == C_LDBU);
  wire upd    = go && (cmd == C_LDAU || cmd == C_LDBU || cmd == C_UPD);
  wire off_a  = go && pdl_n && (cmd == C_OFFA || cmd == C_OFFAB);
  wire off_b  = go && pdl_n && (cmd == C_OFFB || cmd == C_OFFAB);
  wire upo_hi = go && (cmd == C_UPO1);
  wire upo_lo = go && (cmd == C_UPO0);

  assign dout = sr[FW-1];

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      sr     <= '0;
      nbit   <= '0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      if (sclk_rise) sr <= {sr[FW-2:0], din};
      if (cs_fall)
        nbit <= NW'(sclk_rise);
      else if (sclk_rise && nbit != NMAX)
        nbit <= nbit + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      in_a   <= '0;
      in_b   <= '0;
      code_a <= '0;
      code_b <= '0;
    end else begin
      if (ld_a) in_a <= dat;
      if (ld_b) in_b <= dat;
      if (upd) begin
        code_a <= ld_a ? dat : in_a;
        code_b <= ld_b ? dat : in_b;
      end
    end
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      sd_a <= 1'b0;
      sd_b <= 1'b0;
      upo  <= 1'b0;
    end else begin
      if (ld_a || upd) sd_a <= 1'b0;
      else if (off_a)  sd_a <= 1'b1;
      if (ld_b || upd) sd_b <= 1'b0;
      else if (off_b)  sd_b <= 1'b1;
      if (upo_hi)      upo <= 1'b1;
      else if (upo_lo) upo <= 1'b0;
    end
  end

endmodule

// File: rtl/dual_dac_ctrl_chk.sv
module dual_dac_ctrl_chk #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          clr_n,
  input logic          pdl_n,
  input logic          cs_n,
  input logic          dout,
  input logic [DW-1:0] code_a,
  input logic [DW-1:0] code_b,
  input logic          sd_a,
  input logic          sd_b,
  input logic          upo,
  input logic          go
);

  p_code_on_exec_r5: assert property (@(posedge clk) disable iff (!clr_n)
    (code_a != $past(code_a) || code_b != $past(code_b)) |-> $past(go));

  p_lockout_a_r7: assert property (@(posedge clk) disable iff (!clr_n)
    $rose(sd_a) |-> $past(pdl_n));

  p_lockout_b_r7: assert property (@(posedge clk) disable iff (!clr_n)
    $rose(sd_b) |-> $past(pdl_n));

  p_dout_idle_r3: assert property (@(posedge clk) disable iff (!clr_n)
    (cs_n && $past(cs_n)) |-> $stable(dout));

  p_upo_on_exec_r9: assert property (@(posedge clk) disable iff (!clr_n)
    !$stable(upo) |-> $past(go));

  p_clear_r10: assert property (@(posedge clk)
    !clr_n |-> (code_a == '0 && code_b == '0 && !sd_a && !sd_b && !upo && !dout));

endmodule

bind dual_dac_ctrl dual_dac_ctrl_chk #(.DW(DW)) u_chk (.*);

// File: tb/test_dual_dac_ctrl.sv
module test_dual_dac_ctrl;
  localparam int CLK_P = 10;

  logic clk = 1'b0, clr_n = 1'b0, pdl_n = 1'b1, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic dout, sd_a, sd_b, upo;
  logic [11:0] code_a, code_b;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [15:0] e_sr;
  logic [11:0] e_ina, e_inb, e_ca, e_cb;
  logic e_sda, e_sdb, e_upo;

  always #(CLK_P/2) clk = ~clk;

  dual_dac_ctrl i_dual_dac_ctrl (
    .clk(clk), .clr_n(clr_n), .pdl_n(pdl_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .dout(dout), .code_a(code_a), .code_b(code_b), .sd_a(sd_a), .sd_b(sd_b), .upo(upo)
  );

  function automatic void m_clear();
    e_sr = '0; e_ina = '0; e_inb = '0; e_ca = '0; e_cb = '0;
    e_sda = 0; e_sdb = 0; e_upo = 0;
  endfunction

  function automatic void m_exec(input logic [15:0] w, input logic pd);
    logic [3:0] c = w[15:12];
    logic [11:0] d = w[11:0];
    case (c)
      4'h1: begin e_ina = d; e_sda = 0; end
      4'h2: begin e_inb = d; e_sdb = 0; end
      4'h3: begin e_ina = d; e_ca = e_ina; e_cb = e_inb; e_sda = 0; e_sdb = 0; end
      4'h4: begin e_inb = d; e_ca = e_ina; e_cb = e_inb; e_sda = 0; e_sdb = 0; end
      4'h5: begin e_ca = e_ina; e_cb = e_inb; e_sda = 0; e_sdb = 0; end
      4'h6: if (pd) e_sda = 1;
      4'h7: if (pd) e_sdb = 1;
      4'h8: if (pd) begin e_sda = 1; e_sdb = 1; end
      4'h9: e_upo = 0;
      4'hA: e_upo = 1;
      default: ;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic half();
    repeat (2) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    chk({tag, " code_a"}, 32'(code_a), 32'(e_ca));
    chk({tag, " code_b"}, 32'(code_b), 32'(e_cb));
    chk({tag, " sd_a"}, 32'(sd_a), 32'(e_sda));
    chk({tag, " sd_b"}, 32'(sd_b), 32'(e_sdb));
    chk({tag, " upo"}, 32'(upo), 32'(e_upo));
  endtask

  task automatic frame(input logic [15:0] w, input int nb);
    cs_n = 0;
    half();
    for (int i = 0; i < nb; i++) begin
      logic b = (i < 16) ? w[15-i] : w[0];
      din = b;
      chk("R3 dout shift", 32'(dout), 32'(e_sr[15]));
      sclk = 1;
      half();
      e_sr = {e_sr[14:0], b};
      sclk = 0;
      half();
    end
    cs_n = 1;
    half();
    if (nb == 16) m_exec(e_sr, pdl_n);
  endtask

  initial begin
    m_clear();
    #(CLK_P * 3);
    @(negedge clk);
    chk("R10 reset code_a", 32'(code_a), 0);
    chk("R10 reset dout", 32'(dout), 0);
    clr_n = 1;
    half();
    check_all("R10 reset");

    frame(16'h1ABC, 16); check_all("R4 load A");
    chk("R4 code_a held", 32'(code_a), 0);
    frame(16'h2123, 16); check_all("R4 load B");
    frame(16'h5000, 16); check_all("R5 update");
    chk("R1 code_a value", 32'(code_a), 32'h0ABC);
    chk("R5 code_b value", 32'(code_b), 32'h0123);
    frame(16'h4777, 16); check_all("R5 load B + update");
    chk("R5 code_b new", 32'(code_b), 32'h0777);
    frame(16'h3FFF, 16); check_all("R5 load A + update");
    chk("R5 code_a full", 32'(code_a), 32'h0FFF);
    repeat (5) @(negedge clk);
    chk("R3 dout idle", 32'(dout), 32'(e_sr[15]));

    frame(16'h6000, 16); check_all("R6 shutdown A");
    chk("R6 sd_a set", 32'(sd_a), 1);
    frame(16'h1005, 16); frame(16'h6000, 16);
    frame(16'h5000, 16); check_all("R6 input kept");
    chk("R8 sd_a cleared by update", 32'(sd_a), 0);
    frame(16'h8000, 16); check_all("R6 shutdown both");
    frame(16'h1222, 16); check_all("R8 load A wakes A");
    chk("R8 sd_b stays", 32'(sd_b), 1);
    frame(16'h2333, 16); check_all("R8 load B wakes B");

    pdl_n = 0;
    frame(16'h8000, 16); check_all("R7 lockout both");
    chk("R7 sd_a low", 32'(sd_a), 0);
    frame(16'h7000, 16); check_all("R7 lockout B");
    pdl_n = 1;

    frame(16'hA000, 16); check_all("R9 upo set");
    chk("R9 upo high", 32'(upo), 1);
    frame(16'hF5A5, 16); check_all("R9 reserved no effect");
    frame(16'h0FFF, 16); check_all("R9 no-op");
    frame(16'h9000, 16); check_all("R9 upo clear");

    frame(16'h5000, 15); check_all("R2 short frame");
    frame(16'h3111, 17); check_all("R2 long frame");
    frame(16'h3111, 16); check_all("R1 after bad frame");

    for (int n = 0; n < 400; n++) begin
      logic [15:0] w = 16'($urandom());
      int r = int'($urandom_range(0, 19));
      int nb = (r == 0) ? 15 : (r == 1) ? 17 : 16;
      pdl_n = ($urandom_range(0, 3) != 0);
      frame(w, nb);
      check_all("R1 random");
    end

    @(negedge clk);
    clr_n = 0;
    #1;
    m_clear();
    chk("R10 async code_a", 32'(code_a), 0);
    chk("R10 async code_b", 32'(code_b), 0);
    chk("R10 async flags", 32'({sd_a, sd_b, upo}), 0);
    chk("R10 async dout", 32'(dout), 0);
    @(negedge clk);
    clr_n = 1;
    half();
    frame(16'h5000, 16); check_all("R10 after clear");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule